// File: doc/BRIEF.md
# Four-Channel LED Brightness and Blink Generator

This block produces the on/off waveform for four LED outputs. Each channel has its own fast pulse-width modulator with 8-bit resolution. A channel can be held off, held on, driven by its own modulator, or driven by its own modulator ANDed with one group signal that all four channels share. The group signal is a second, much slower modulator. In dimming mode it sets an overall brightness. In blink mode its step length is stretched by a period setting, so the LEDs flash with a programmable rate and on-fraction.

The block takes register values as plain inputs. Brightness and channel selections are copied into the block at the start of each fast PWM period. Group duty, group period and group mode are copied at the start of each group period, so a write never cuts a pulse short. An active-low enable input overrides all four pins with a chosen level or high impedance. An open-drain option turns every driven-high level into high impedance. Each pin is presented as a data bit plus a driver-enable bit.

Top module: `ledpwm_top`

## Requirements
- R1: After reset, and until the first fast-period boundary (2^W clocks later), every channel behaves as selection 00 (logic 0). The group settings reset to dimming mode, duty all-ones and period 0.
- R2: Channel selection 00 gives a constant logic 0 and selection 01 gives a constant logic 1.
- R3: Selection 10 gives logic 1 while the fast counter position, 0 to 2^W-1 counted from the period start, is below the channel brightness B. The channel is high for B of every 2^W clocks, and B = 0 means never high.
- R4: Selection 11 gives the channel's R3 signal ANDed with the group signal.
- R5: In dimming mode (mode input 0), the group position advances by one every DIM_DIV fast periods, aligned to fast-period ends. The group signal is 1 while the position is below the group duty G.
- R6: In blink mode (mode input 1), each group step lasts (P+1)*BLINK_PRE clocks, where P is the period setting, so a full blink is 2^W such steps. The group signal is 1 for the first G steps, and G = 0 means never on.
- R7: Changes to brightness or selection act from the next fast-period start. Changes to group duty, period or mode act from the next group-period start.
- R8: While the enable input is high, every pin follows the force code at once: 01 means logic 0, 10 means logic 1, and 00 or 11 means high impedance (driver enable 0).
- R9: With open-drain select at 1, a logic 1 gives driver enable 0 and a logic 0 gives data 0 with enable 1. With the select at 0, each pin drives its logic level with enable 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bright_i | input | NUM_LED*W | Per-channel brightness, channel i in bits [W*i +: W] |
| led_sel_i | input | NUM_LED*2 | Per-channel selection code, channel i in bits [2*i +: 2] |
| grp_duty_i | input | W | Group duty G |
| grp_period_i | input | W | Blink period setting P |
| grp_blink_i | input | 1 | Group mode: 0 dimming, 1 blink |
| oe_n_i | input | 1 | Active-low output enable |
| oe_force_i | input | 2 | Pin value while disabled |
| od_mode_i | input | 1 | 1 selects open-drain pins |
| led_out_o | output | NUM_LED | Pin data level |
| led_en_o | output | NUM_LED | Pin driver enable (0 means high impedance) |

## Verification
A fast counter that is off by one, or a brightness copy taken at the wrong moment, shifts or shortens a channel's high time within a single fast period of 2^W clocks. A misbehaving group position or step counter first shows on selection-11 channels, at the end of the group step where it goes wrong: 2^W*DIM_DIV clocks in dimming mode, or (P+1)*BLINK_PRE clocks in blink mode. A mistake in the group settings copy only shows one full group period after the write, which is why the sweeps run longer than one group period. Enable and open-drain faults are combinational and show in the same cycle that the inputs change.

// File: rtl/ledpwm_pkg.sv
package ledpwm_pkg;

    typedef enum logic [1:0] {
        LS_OFF = 2'b00,
        LS_ON  = 2'b01,
        LS_IND = 2'b10,
        LS_GRP = 2'b11
    } led_sel_e;

    typedef enum logic [1:0] {
        FRC_HIZ  = 2'b00,
        FRC_LOW  = 2'b01,
        FRC_HIGH = 2'b10,
        FRC_HIZB = 2'b11
    } oe_force_e;

    typedef enum logic {
        GM_DIM   = 1'b0,
        GM_BLINK = 1'b1
    } grp_mode_e;

    typedef struct packed {
        logic drv;
        logic en;
    } pin_t;

    function automatic logic sel_level(led_sel_e s, logic ind, logic grp);
        case (s)
            LS_OFF:  return 1'b0;
            LS_ON:   return 1'b1;
            LS_IND:  return ind;
            default: return ind & grp;
        endcase
    endfunction

    function automatic pin_t pin_map(logic lvl, logic od);
        pin_t p;
        p.drv = od ? 1'b0 : lvl;
        p.en  = od ? ~lvl : 1'b1;
        return p;
    endfunction

    function automatic pin_t drive_pin(logic lvl, logic oe_n, oe_force_e f, logic od);
        pin_t p;
        if (!oe_n) begin
            p = pin_map(lvl, od);
        end else begin
            case (f)
                FRC_LOW:  p = pin_map(1'b0, od);
                FRC_HIGH: p = pin_map(1'b1, od);
                default:  p = '{drv: 1'b0, en: 1'b0};
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/ledpwm_base.sv
module ledpwm_base #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] fcnt;

    always_ff @(posedge clk) begin
        if (rst) fcnt <= '0;
        else     fcnt <= fcnt + 1'b1;
    end

    assign cnt_o  = fcnt;
    assign wrap_o = (fcnt == '1);

    // R3
    period_restart_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (cnt_o == '0));
endmodule

// File: rtl/ledpwm_group.sv
module ledpwm_group
    import ledpwm_pkg::*;
#(
    parameter int W         = 8,
    parameter int DIM_DIV   = 2,
    parameter int BLINK_PRE = 4069
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wrap_i,
    input  logic [W-1:0] duty_i,
    input  logic [W-1:0] period_i,
    input  grp_mode_e    mode_i,
    output logic         grp_on_o
);
    localparam int DW = (DIM_DIV > 1) ? $clog2(DIM_DIV) : 1;
    localparam int PW = (BLINK_PRE > 1) ? $clog2(BLINK_PRE) : 1;

    logic [W-1:0]  gcnt, duty_q, per_q, scnt;
    grp_mode_e     mode_q;
    logic [DW-1:0] dcnt;
    logic [PW-1:0] pcnt;
    logic          pre_end, dim_tick, blink_tick, tick, gwrap;

    always_comb begin
        pre_end    = (pcnt == PW'(BLINK_PRE - 1));
        dim_tick   = (mode_q == GM_DIM) && wrap_i && (dcnt == DW'(DIM_DIV - 1));
        blink_tick = (mode_q == GM_BLINK) && pre_end && (scnt == per_q);
        tick       = dim_tick | blink_tick;
        gwrap      = tick && (gcnt == '1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gcnt   <= '0;
            duty_q <= '1;
            per_q  <= '0;
            mode_q <= GM_DIM;
            dcnt   <= '0;
            pcnt   <= '0;
            scnt   <= '0;
        end else if (tick) begin
            gcnt <= gcnt + 1'b1;
            dcnt <= '0;
            pcnt <= '0;
            scnt <= '0;
            if (gwrap) begin
                duty_q <= duty_i;
                per_q  <= period_i;
                mode_q <= mode_i;
            end
        end else if (mode_q == GM_DIM) begin
            if (wrap_i) dcnt <= dcnt + 1'b1;
        end else begin
            if (pre_end) begin
                pcnt <= '0;
                scnt <= scnt + 1'b1;
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    assign grp_on_o = (gcnt < duty_q);

    // R5
    grp_step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(gcnt));

    // R7
    grp_cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !gwrap |=> ($stable(duty_q) && $stable(per_q) && $stable(mode_q)));

    // R6
    grp_zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (duty_q == '0) |-> !grp_on_o);
endmodule

// File: rtl/ledpwm_chan.sv
module ledpwm_chan
    import ledpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wrap_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] bright_i,
    input  led_sel_e     sel_i,
    input  logic         grp_on_i,
    input  logic         oe_n_i,
    input  oe_force_e    force_i,
    input  logic         od_i,
    output logic         out_o,
    output logic         en_o
);
    logic [W-1:0] bright_q;
    led_sel_e     sel_q;
    logic         ind_on, lvl;
    pin_t         pin;

    always_ff @(posedge clk) begin
        if (rst) begin
            bright_q <= '0;
            sel_q    <= LS_OFF;
        end else if (wrap_i) begin
            bright_q <= bright_i;
            sel_q    <= sel_i;
        end
    end

    always_comb begin
        ind_on = (cnt_i < bright_q);
        lvl    = sel_level(sel_q, ind_on, grp_on_i);
        pin    = drive_pin(lvl, oe_n_i, force_i, od_i);
    end

    assign out_o = pin.drv;
    assign en_o  = pin.en;

    // R7
    chan_cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap_i |=> ($stable(bright_q) && $stable(sel_q)));

    // R3
    zero_bright_chk: assert property (@(posedge clk) disable iff (rst)
        (bright_q == '0) |-> !ind_on);

    // R8
    force_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_n_i && (force_i == FRC_HIZ || force_i == FRC_HIZB)) |-> !en_o);

    // R9
    od_no_high_chk: assert property (@(posedge clk) disable iff (rst)
        (od_i && en_o) |-> !out_o);

    // R2
    held_on_chk: assert property (@(posedge clk) disable iff (rst)
        (!oe_n_i && !od_i && sel_q == LS_ON) |-> (out_o && en_o));
endmodule

// File: rtl/ledpwm_top.sv
module ledpwm_top
    import ledpwm_pkg::*;
#(
    parameter int NUM_LED   = 4,
    parameter int W         = 8,
    parameter int DIM_DIV   = 2,
    parameter int BLINK_PRE = 4069
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LED*W-1:0] bright_i,
    input  logic [NUM_LED*2-1:0] led_sel_i,
    input  logic [W-1:0]         grp_duty_i,
    input  logic [W-1:0]         grp_period_i,
    input  logic                 grp_blink_i,
    input  logic                 oe_n_i,
    input  logic [1:0]           oe_force_i,
    input  logic                 od_mode_i,
    output logic [NUM_LED-1:0]   led_out_o,
    output logic [NUM_LED-1:0]   led_en_o
);
    logic [W-1:0] fcnt;
    logic         fwrap, grp_on;

    ledpwm_base #(.W(W)) u_base (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (fcnt),
        .wrap_o (fwrap)
    );

    ledpwm_group #(.W(W), .DIM_DIV(DIM_DIV), .BLINK_PRE(BLINK_PRE)) u_group (
        .clk      (clk),
        .rst      (rst),
        .wrap_i   (fwrap),
        .duty_i   (grp_duty_i),
        .period_i (grp_period_i),
        .mode_i   (grp_mode_e'(grp_blink_i)),
        .grp_on_o (grp_on)
    );

    for (genvar i = 0; i < NUM_LED; i++) begin : g_chan
        ledpwm_chan #(.W(W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .wrap_i   (fwrap),
            .cnt_i    (fcnt),
            .bright_i (bright_i[W*i +: W]),
            .sel_i    (led_sel_e'(led_sel_i[2*i +: 2])),
            .grp_on_i (grp_on),
            .oe_n_i   (oe_n_i),
            .force_i  (oe_force_e'(oe_force_i)),
            .od_i     (od_mode_i),
            .out_o    (led_out_o[i]),
            .en_o     (led_en_o[i])
        );
    end
endmodule

// File: tb/ledpwm_top_tb.sv
module ledpwm_top_tb;
    localparam int N   = 4;
    localparam int W   = 4;
    localparam int DD  = 2;
    localparam int BP  = 3;
    localparam int PER = 1 << W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int b_in[N];
    int s_in[N];
    int g_duty = 15, g_per = 0, g_blink = 0;
    int oe_n = 0, force_c = 0, od = 0;

    logic [N*W-1:0] bright_v;
    logic [N*2-1:0] sel_v;
    logic [N-1:0]   led_out, led_en;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            bright_v[W*i +: W] = W'(b_in[i]);
            sel_v[2*i +: 2]    = 2'(s_in[i]);
        end
    end

    ledpwm_top #(.NUM_LED(N), .W(W), .DIM_DIV(DD), .BLINK_PRE(BP)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .bright_i     (bright_v),
        .led_sel_i    (sel_v),
        .grp_duty_i   (W'(g_duty)),
        .grp_period_i (W'(g_per)),
        .grp_blink_i  (g_blink[0]),
        .oe_n_i       (oe_n[0]),
        .oe_force_i   (2'(force_c)),
        .od_mode_i    (od[0]),
        .led_out_o    (led_out),
        .led_en_o     (led_en)
    );

    int checks = 0, fails = 0;
    int cyc, last_wr;
    int bsh[N];
    int ssh[N];
    int gpos, gsub, gd_sh, gp_sh, gm_sh;

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            bsh[i] = 0;
            ssh[i] = 0;
        end
        gd_sh = PER - 1; gp_sh = 0; gm_sh = 0;
        gpos = 0; gsub = 0; cyc = 0; last_wr = -1000;
        rst = 1'b0;
    endtask

    task automatic check_now();
        #1;
        for (int i = 0; i < N; i++) begin
            int pos;
            bit ind, grp, lvl, eo, ee;
            string tag;
            pos = cyc % PER;
            ind = (pos < bsh[i]);
            grp = (gpos < gd_sh);
            case (ssh[i])
                0: begin lvl = 1'b0; tag = "R2"; end
                1: begin lvl = 1'b1; tag = "R2"; end
                2: begin lvl = ind;  tag = "R3"; end
                default: begin lvl = ind & grp; tag = gm_sh ? "R4/R6" : "R4/R5"; end
            endcase
            if (cyc < PER) tag = "R1";
            if (oe_n != 0) begin
                tag = "R8";
                if (force_c == 1) lvl = 1'b0;
                else if (force_c == 2) lvl = 1'b1;
            end
            if (oe_n != 0 && (force_c == 0 || force_c == 3)) begin
                eo = 1'b0; ee = 1'b0;
            end else if (od != 0) begin
                eo = 1'b0; ee = ~lvl;
                if (lvl) tag = {tag, " R9"};
            end else begin
                eo = lvl; ee = 1'b1;
            end
            if (cyc - last_wr < 2 * PER) tag = {"R7 ", tag};
            checks++;
            if (led_out[i] !== eo || led_en[i] !== ee) begin
                fails++;
                $display("FAIL %s led%0d cyc %0d: got out=%0b en=%0b expected out=%0b en=%0b",
                         tag, i, cyc, led_out[i], led_en[i], eo, ee);
            end
        end
    endtask

    task automatic advance_model();
        int len;
        if (cyc % PER == PER - 1) begin
            for (int i = 0; i < N; i++) begin
                bsh[i] = b_in[i];
                ssh[i] = s_in[i];
            end
        end
        len = gm_sh ? (gp_sh + 1) * BP : PER * DD;
        if (gsub == len - 1) begin
            gsub = 0;
            if (gpos == PER - 1) begin
                gpos = 0;
                gd_sh = g_duty; gp_sh = g_per; gm_sh = g_blink;
            end else begin
                gpos++;
            end
        end else begin
            gsub++;
        end
        cyc++;
    endtask

    task automatic run(int n);
        repeat (n) begin
            check_now();
            @(posedge clk);
            advance_model();
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            b_in[i] = 9;
            s_in[i] = 1;
        end

        // R1, R2: defaults hold for the first fast period, then held-on
        do_reset();
        run(40);
        for (int i = 0; i < N; i++) s_in[i] = 0;
        last_wr = cyc;
        run(40);

        // R3, R7: brightness sweep, changed at unaligned points
        for (int i = 0; i < N; i++) s_in[i] = 2;
        for (int b = 0; b < PER; b++) begin
            b_in[0] = b;
            b_in[1] = PER - 1 - b;
            b_in[2] = b ^ 5;
            b_in[3] = (b * 3) % PER;
            last_wr = cyc;
            run(37);
        end

        // R4, R5: dimming, default duty then duty 5
        g_duty = 5;
        b_in[0] = 15; b_in[1] = 8; b_in[2] = 1; b_in[3] = 0;
        for (int i = 0; i < N; i++) s_in[i] = 3;
        s_in[3] = 2;
        do_reset();
        run(1100);

        // R6: blink with period 1, duty 9, then duty 0 and period 2
        g_blink = 1; g_per = 1; g_duty = 9;
        do_reset();
        run(512 + 300);
        g_duty = 0; g_per = 2;
        last_wr = cyc;
        run(360);

        // R8, R9: enable forcing and open-drain over all codes
        s_in[0] = 1; s_in[1] = 0; s_in[2] = 3; s_in[3] = 2;
        g_duty = 12;
        for (int f = 0; f < 4; f++) begin
            for (int o = 0; o < 2; o++) begin
                force_c = f; od = o;
                oe_n = 1;
                run(5);
                oe_n = 0;
                run(7);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule